// File: doc/BRIEF.md
# FIFO Bus-Width Adapter with Selectable Byte Order

This block sits on both sides of a FIFO whose storage word is 36 bits wide. It lets the write and read ports have different widths. On the write side it gathers two 18-bit halves or four 9-bit bytes into one 36-bit entry before handing it to storage. On the read side it splits each 36-bit entry from storage into two or four narrow words. A byte-order setting decides which end of the 36-bit word the first narrow word occupies.

Input width, output width and byte order come from configuration pins. These pins are captured only while master reset is high, so they can be strapped or driven during reset and then left alone. A partial reset empties the data path and keeps the captured configuration.

Every data interface is valid/ready. A transfer happens on a rising edge where both valid and ready are high. Once a source raises valid, it keeps valid and data steady until the transfer completes. The write input stalls only when a finished group cannot move into the one-entry output holding register. The read side pulls the next storage entry only when the last narrow word of the current one is being taken.

Top module: `fifo_width_adapter`

## Requirements
- R1: Width codes are 0 = 36 bits, 1 = 18 bits and 2 = 9 bits. The accepted input/output pairs are 36/36, 36/18, 36/9, 18/36 and 9/36. Any other combination of codes, including code 3, runs as 36/36.
- R2: The width and byte-order pins are captured on every clock edge while `mrst` is high. Outside master reset, changes on these pins have no effect on behaviour.
- R3: When `cfg_big_endian` = 1, narrow word k of a write group (counting from 0) is placed in lane N-1-k of the stored word. Lane j covers bits [j*W +: W], W is the input width and N = 36/W. Only the low W bits of `in_data` are used.
- R4: When `cfg_big_endian` = 0, narrow word k of a write group is placed in lane k.
- R5: A 36-bit entry is offered on `st_wr_valid` in the cycle after the last narrow word of its group is accepted. Earlier words of the group produce no storage write.
- R6: On the read side, narrow word k of an entry is lane N-1-k when big-endian and lane k when little-endian. W is the output width and N = 36/W. The word appears in the low W bits of `out_data`, and the upper bits are zero.
- R7: `st_rd_ready` is low whenever `out_valid` is high and `out_ready` is low. A new entry is taken only after every narrow word of the current entry has been delivered.
- R8: Once `st_wr_valid` or `out_valid` is high, that valid and its data stay unchanged until the matching ready is seen.
- R9: `in_ready` goes low only when the incoming word would complete a group while a finished entry is still waiting and `st_wr_ready` is low.
- R10: A pulse on `prst` discards a partly gathered group and any word waiting in the adapter. The captured widths and byte order are kept.
- R11: In the cycle after `mrst` or `prst` is high, `st_wr_valid` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst | input | 1 | Synchronous master reset; captures configuration |
| prst | input | 1 | Synchronous partial reset; clears data path only |
| cfg_in_width | input | 2 | Write-side width code |
| cfg_out_width | input | 2 | Read-side width code |
| cfg_big_endian | input | 1 | 1 = first narrow word at the most significant end |
| in_valid | input | 1 | Write word valid |
| in_ready | output | 1 | Adapter accepts write word |
| in_data | input | 36 | Write word, narrow data in low bits |
| st_wr_valid | output | 1 | Packed entry valid toward storage |
| st_wr_ready | input | 1 | Storage accepts entry |
| st_wr_data | output | 36 | Packed entry |
| st_rd_valid | input | 1 | Storage entry available |
| st_rd_ready | output | 1 | Adapter takes storage entry |
| st_rd_data | input | 36 | Entry read from storage |
| out_valid | output | 1 | Read word valid |
| out_ready | input | 1 | Consumer takes read word |
| out_data | output | 36 | Read word, narrow data in low bits |

## Verification
Some rules are checked by assertions on every cycle. These cover the handshake hold rules of both outputs, the ban on fetching while a narrow word is stalled, the fact that configuration never moves outside master reset, the idle outputs after either reset, and the fact that a storage write always follows an accepted input word. Other behaviour can only be shown by the bench's scenarios. These are the exact placement of lanes for each width pair and byte order, the folding of illegal code pairs to 36/36, the masking of unused input bits, stalls under back-pressure, and the loss of a partial group across a partial reset.

// File: rtl/fwa_pkg.sv
`timescale 1ns/1ps
package fwa_pkg;
  localparam int WORD_W = 36;
  localparam int LANE_W = 9;
  localparam int MAX_LANES = WORD_W / LANE_W;
  localparam int IDX_W = $clog2(MAX_LANES);
  localparam int POS_W = $clog2(WORD_W);

  typedef enum logic [1:0] {W36 = 2'd0, W18 = 2'd1, W9 = 2'd2} width_e;

  typedef struct packed {
    width_e in_w;
    width_e out_w;
    logic   big_end;
  } cfg_t;

  function automatic logic [IDX_W-1:0] last_lane(width_e w);
    case (w)
      W18:     return IDX_W'(1);
      W9:      return IDX_W'(MAX_LANES - 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] lane_width(width_e w);
    case (w)
      W18:     return POS_W'(2 * LANE_W);
      W9:      return POS_W'(LANE_W);
      default: return POS_W'(WORD_W);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] lane_lsb(width_e w, logic be,
                                                logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] pos;
    pos = be ? (last_lane(w) - idx) : idx;
    return POS_W'(32'(pos) * 32'(lane_width(w)));
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(width_e w);
    if (w == W36) return '1;
    return (WORD_W'(1) << lane_width(w)) - WORD_W'(1);
  endfunction

  function automatic cfg_t resolve_cfg(logic [1:0] i, logic [1:0] o, logic be);
    cfg_t c;
    logic ok;
    ok = (i != 2'd3) && (o != 2'd3) && ((i == 2'd0) || (o == 2'd0));
    c.in_w    = ok ? width_e'(i) : W36;
    c.out_w   = ok ? width_e'(o) : W36;
    c.big_end = be;
    return c;
  endfunction
endpackage

// File: rtl/fwa_cfg_latch.sv
`timescale 1ns/1ps
module fwa_cfg_latch
  import fwa_pkg::*;
(
  input  logic       clk,
  input  logic       mrst,
  input  logic [1:0] in_code,
  input  logic [1:0] out_code,
  input  logic       be_pin,
  output cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (mrst) cfg <= resolve_cfg(in_code, out_code, be_pin);
  end
endmodule

// File: rtl/fwa_packer.sv
`timescale 1ns/1ps
module fwa_packer
  import fwa_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  width_e            in_w,
  input  logic              big_end,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data
);
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;
  logic              group_end;
  logic              take;

  assign group_end = (idx == last_lane(in_w));
  assign in_ready  = !group_end || !st_valid || st_ready;
  assign take      = in_valid && in_ready;
  assign merged    = acc | ((in_data & lane_mask(in_w)) << lane_lsb(in_w, big_end, idx));

  always_ff @(posedge clk) begin
    if (clr) begin
      idx      <= '0;
      acc      <= '0;
      st_valid <= 1'b0;
      st_data  <= '0;
    end else begin
      if (st_valid && st_ready) st_valid <= 1'b0;
      if (take) begin
        if (group_end) begin
          st_data  <= merged;
          st_valid <= 1'b1;
          acc      <= '0;
          idx      <= '0;
        end else begin
          acc <= merged;
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fwa_unpacker.sv
`timescale 1ns/1ps
module fwa_unpacker
  import fwa_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  width_e            out_w,
  input  logic              big_end,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [WORD_W-1:0] st_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] cur;
  logic              cur_valid;
  logic              final_lane;

  assign final_lane = (idx == last_lane(out_w));
  assign st_ready   = !cur_valid || (out_ready && final_lane);
  assign out_valid  = cur_valid;
  assign out_data   = (cur >> lane_lsb(out_w, big_end, idx)) & lane_mask(out_w);

  always_ff @(posedge clk) begin
    if (clr) begin
      cur_valid <= 1'b0;
      cur       <= '0;
      idx       <= '0;
    end else if (st_ready) begin
      cur_valid <= st_valid;
      if (st_valid) cur <= st_data;
      idx <= '0;
    end else if (out_ready) begin
      idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/fifo_width_adapter.sv
`timescale 1ns/1ps
module fifo_width_adapter
  import fwa_pkg::*;
(
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic [1:0]        cfg_in_width,
  input  logic [1:0]        cfg_out_width,
  input  logic              cfg_big_endian,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              st_wr_valid,
  input  logic              st_wr_ready,
  output logic [WORD_W-1:0] st_wr_data,
  input  logic              st_rd_valid,
  output logic              st_rd_ready,
  input  logic [WORD_W-1:0] st_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  cfg_t cfg;
  logic path_clr;

  assign path_clr = mrst || prst;

  fwa_cfg_latch u_cfg (
    .clk      (clk),
    .mrst     (mrst),
    .in_code  (cfg_in_width),
    .out_code (cfg_out_width),
    .be_pin   (cfg_big_endian),
    .cfg      (cfg)
  );

  fwa_packer u_pack (
    .clk      (clk),
    .clr      (path_clr),
    .in_w     (cfg.in_w),
    .big_end  (cfg.big_end),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .st_valid (st_wr_valid),
    .st_ready (st_wr_ready),
    .st_data  (st_wr_data)
  );

  fwa_unpacker u_unpack (
    .clk       (clk),
    .clr       (path_clr),
    .out_w     (cfg.out_w),
    .big_end   (cfg.big_end),
    .st_valid  (st_rd_valid),
    .st_ready  (st_rd_ready),
    .st_data   (st_rd_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/fwa_checker.sv
`timescale 1ns/1ps
module fwa_checker
  import fwa_pkg::*;
(
  input logic              clk,
  input logic              mrst,
  input logic              prst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              st_wr_valid,
  input logic              st_wr_ready,
  input logic [WORD_W-1:0] st_wr_data,
  input logic              st_rd_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input cfg_t              cfg
);
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(cfg));

  assert_commit_follows_input_R5: assert property (@(posedge clk) disable iff (mrst || prst)
    $rose(st_wr_valid) |-> $past(in_valid && in_ready));

  assert_no_early_fetch_R7: assert property (@(posedge clk) disable iff (mrst)
    (out_valid && !out_ready) |-> !st_rd_ready);

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (mrst || prst)
    (st_wr_valid && !st_wr_ready) |=> (st_wr_valid && $stable(st_wr_data)));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (mrst || prst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_clear_idle_R11: assert property (@(posedge clk)
    (mrst || prst) |=> (!st_wr_valid && !out_valid));
endmodule

bind fifo_width_adapter fwa_checker u_chk (.*);

// File: tb/test_fifo_width_adapter.sv
`timescale 1ns/1ps
module test_fifo_width_adapter;
  logic        clk = 1'b0;
  logic        mrst = 1'b1, prst = 1'b0;
  logic [1:0]  cfg_in_width = 2'd0, cfg_out_width = 2'd0;
  logic        cfg_big_endian = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [35:0] in_data = '0;
  logic        st_wr_valid, st_wr_ready = 1'b1;
  logic [35:0] st_wr_data;
  logic        st_rd_valid, st_rd_ready;
  logic [35:0] st_rd_data;
  logic        out_valid, out_ready = 1'b0;
  logic [35:0] out_data;

  int tests = 0, fails = 0;
  logic [35:0] rd_mem [0:7];
  int          rd_cnt = 0, rd_ptr = 0;
  logic        rd_clr = 1'b0;
  logic [35:0] cap [0:15];
  int          cap_n;
  logic [35:0] ocap [0:31];
  int          ocap_n;

  always #10 clk = ~clk;

  assign st_rd_valid = (rd_ptr < rd_cnt);
  assign st_rd_data  = rd_mem[rd_ptr[2:0]];
  always @(posedge clk) begin
    if (rd_clr) rd_ptr <= 0;
    else if (st_rd_valid && st_rd_ready) rd_ptr <= rd_ptr + 1;
  end

  fifo_width_adapter i_fifo_width_adapter (.*);

  task automatic check(bit ok, string req, string what, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lanes_of(int code);
    return (code == 1) ? 2 : (code == 2) ? 4 : 1;
  endfunction
  function automatic int width_of(int code);
    return 36 / lanes_of(code);
  endfunction
  function automatic logic [35:0] mask_of(int code);
    return (width_of(code) == 36) ? '1 : ((36'd1 << width_of(code)) - 36'd1);
  endfunction
  function automatic logic [35:0] gen(int seed, int j);
    return {4'(j * 5 + seed), 32'(seed * 40503 + j * 2654435 + 17)};
  endfunction

  int eff_in, eff_out;
  bit be;

  task automatic apply_reset(int ic, int oc, bit bend);
    bit legal;
    @(negedge clk);
    cfg_in_width = 2'(ic); cfg_out_width = 2'(oc); cfg_big_endian = bend;
    mrst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; rd_cnt = 0; rd_clr = 1'b1;
    @(negedge clk);
    mrst = 1'b0; rd_clr = 1'b0;
    // scramble pins after capture: must be ignored (R2)
    cfg_in_width = 2'd3; cfg_out_width = 2'd1; cfg_big_endian = ~bend;
    legal = (ic != 3) && (oc != 3) && (ic == 0 || oc == 0);
    eff_in = legal ? ic : 0; eff_out = legal ? oc : 0; be = bend;
    #1;
    check(!st_wr_valid && !out_valid && in_ready && st_rd_ready, "R11", "idle after reset",
          {32'd0, st_wr_valid, out_valid, in_ready, st_rd_ready}, 36'h3);
  endtask

  task automatic run_write(int seed);
    int n = lanes_of(eff_in);
    int total = 4 * n;
    int j = 0;
    logic [35:0] exp;
    cap_n = 0; st_wr_ready = 1'b1;
    for (int c = 0; c < total + 4; c++) begin
      @(negedge clk); #1;
      if (st_wr_valid && st_wr_ready && cap_n < 16) begin cap[cap_n] = st_wr_data; cap_n++; end
      if (j < total) begin in_valid = 1'b1; in_data = gen(seed, j); j++; end
      else in_valid = 1'b0;
    end
    check(cap_n == 4, "R5", "storage write count", 36'(cap_n), 36'd4);
    for (int g = 0; g < 4 && g < cap_n; g++) begin
      exp = '0;
      for (int k = 0; k < n; k++) begin
        int pos = be ? (n - 1 - k) : k;
        exp |= (gen(seed, g * n + k) & mask_of(eff_in)) << (pos * width_of(eff_in));
      end
      check(cap[g] == exp, be ? "R3" : "R4", "packed entry", cap[g], exp);
    end
  endtask

  task automatic run_read(int seed);
    int n = lanes_of(eff_out);
    logic [35:0] exp;
    for (int g = 0; g < 4; g++) rd_mem[g] = gen(seed + 7, g) ^ 36'hC_3A5F_0F0F;
    ocap_n = 0;
    @(negedge clk); rd_cnt = 4;
    for (int c = 0; c < 4 * n * 3 + 10; c++) begin
      @(negedge clk);
      out_ready = (c % 3) != 1;
      #1;
      if (out_valid && !out_ready && st_rd_ready)
        check(0, "R7", "fetch while word stalled", 36'(st_rd_ready), 36'd0);
      if (out_valid && out_ready && ocap_n < 32) begin ocap[ocap_n] = out_data; ocap_n++; end
    end
    out_ready = 1'b0;
    check(ocap_n == 4 * n, "R7", "read word count", 36'(ocap_n), 36'(4 * n));
    for (int g = 0; g < 4; g++)
      for (int k = 0; k < n; k++) begin
        int pos = be ? (n - 1 - k) : k;
        int idx = g * n + k;
        exp = (rd_mem[g] >> (pos * width_of(eff_out))) & mask_of(eff_out);
        if (idx < ocap_n) check(ocap[idx] == exp, "R6", "unpacked word", ocap[idx], exp);
      end
  endtask

  initial begin
    #(20 * 150000);
    check(0, "WATCHDOG", "timeout", 36'd0, 36'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: sweep every code pair and both byte orders
    for (int ic = 0; ic < 4; ic++)
      for (int oc = 0; oc < 4; oc++)
        for (int b = 0; b < 2; b++) begin
          apply_reset(ic, oc, b[0]);
          run_write(ic * 8 + oc * 2 + b + 1);
          run_read(ic * 8 + oc * 2 + b + 3);
        end

    // R9 / R8: back-pressure in 36/36
    apply_reset(0, 0, 1'b0);
    st_wr_ready = 1'b0;
    @(negedge clk); in_valid = 1'b1; in_data = 36'hA_1111_2222;
    @(negedge clk); in_data = 36'hB_3333_4444; #1;
    check(st_wr_valid && st_wr_data == 36'hA_1111_2222, "R8", "entry offered", st_wr_data, 36'hA_1111_2222);
    check(!in_ready, "R9", "input stalled", 36'(in_ready), 36'd0);
    @(negedge clk); #1;
    check(st_wr_valid && st_wr_data == 36'hA_1111_2222, "R8", "entry held", st_wr_data, 36'hA_1111_2222);
    st_wr_ready = 1'b1; #1;
    check(in_ready, "R9", "input released", 36'(in_ready), 36'd1);
    @(negedge clk); in_valid = 1'b0; #1;
    check(st_wr_valid && st_wr_data == 36'hB_3333_4444, "R9", "second entry", st_wr_data, 36'hB_3333_4444);

    // R9: narrow non-final words still accepted while entry waits
    apply_reset(2, 0, 1'b1);
    st_wr_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); in_valid = 1'b1; in_data = 36'(k + 1); end
    @(negedge clk); in_data = 36'h5; #1;
    check(in_ready, "R9", "narrow word accepted while entry waits", 36'(in_ready), 36'd1);
    @(negedge clk); in_valid = 1'b0;
    st_wr_ready = 1'b1;

    // R10: partial reset drops partial group, keeps 9-in big-endian config
    apply_reset(2, 0, 1'b1);
    @(negedge clk); in_valid = 1'b1; in_data = 36'h11;
    @(negedge clk); in_data = 36'h22;
    @(negedge clk); in_valid = 1'b0; prst = 1'b1;
    @(negedge clk); prst = 1'b0; #1;
    check(!st_wr_valid && !out_valid, "R11", "idle after partial reset", 36'(st_wr_valid), 36'd0);
    cap_n = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); #1;
      if (st_wr_valid && cap_n < 16) begin cap[cap_n] = st_wr_data; cap_n++; end
      if (c < 4) begin in_valid = 1'b1; in_data = 36'(8'hA1 + c); end else in_valid = 1'b0;
    end
    check(cap_n == 1, "R10", "one entry after partial reset", 36'(cap_n), 36'd1);
    check(cap[0] == ((36'hA1 << 27) | (36'hA2 << 18) | (36'hA3 << 9) | 36'hA4), "R10",
          "entry built from new words only", cap[0],
          (36'hA1 << 27) | (36'hA2 << 18) | (36'hA3 << 9) | 36'hA4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule